// File: doc/BRIEF.md
# Message RAM Transfer Request Controller

This block moves one message object at a time between a single interface data buffer and a 32-entry single-port message RAM. Software starts a transfer by writing an object number into a 16-bit command register. That write is the only trigger. A direction input, sampled with the same write, chooses the direction. In store direction the buffer is copied into the RAM entry. In fetch direction the RAM entry is copied into the buffer.

An object number outside 1..32 is folded back into that range before use. The folded value is what the register returns on readback. The busy flag rises with the accepted write and stays high for a fixed four-clock transfer window. While busy is high, new commands and buffer loads are ignored.

The buffer is loaded through a valid/ready input. Ready is low for the whole transfer window, so a source that holds valid simply waits. The buffer contents are always visible on a plain output. A separate flag marks the contents as fresh data from a completed fetch.

Top module: `msgx_top`

## Requirements
- R1: After reset, the command readback is 0x0001, busy is 0, the fetched-data flag is 0 and buffer-in ready is 1.
- R2: Readback layout: bit 15 is busy, bits 5:0 are the current object number, and bits 14:6 read as zero. Write data in bits 15:6 has no effect.
- R3: A written number from 0x01 to 0x20 selects that object unchanged and reads back unchanged.
- R4: A written number of 0x00 selects object 0x20 and reads back as 0x20.
- R5: A written number from 0x21 to 0x3F selects that number minus 0x20 (0x21 gives 0x01, 0x3F gives 0x1F).
- R6: An accepted command write makes busy read 1 from the next clock. Busy stays 1 for exactly 4 clocks, then returns to 0.
- R7: With the direction input at 1 (store), the buffer value is written into the RAM entry of the remapped object.
- R8: With the direction input at 0 (fetch), the RAM entry of the remapped object is copied into the buffer. The fetched-data flag rises in the same clock that busy falls.
- R9: A command write while busy is high is ignored. The object number, the direction and the end time of the running transfer are unchanged.
- R10: Buffer-in ready equals not-busy. A load happens only on valid and ready, replaces the buffer and clears the fetched-data flag. Valid held while busy does not change the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command register write data |
| xfer_store | input | 1 | Direction sampled at command write: 1 store buffer to RAM, 0 fetch RAM to buffer |
| cmd_rdata | output | 16 | Command register readback |
| busy | output | 1 | Transfer in progress |
| bin_valid | input | 1 | Buffer load data valid |
| bin_ready | output | 1 | Buffer can accept a load |
| bin_data | input | 64 | Buffer load data |
| buf_data | output | 64 | Current buffer contents |
| buf_fetched | output | 1 | Buffer holds data from a completed fetch |

## Verification
Commands are issued with numbers from each remap class: 0x00, the valid bounds 0x01 and 0x20, a mid value, 0x21 and 0x3F, plus a write with junk in the upper bits. Readback then tells correct folding apart from truncation or pass-through. Store-then-fetch round trips go through aliased numbers, for example 0x23 against 0x03 and 0x00 against 0x20. Distinct data patterns separate a wrong RAM entry from a wrong direction. Commands and buffer loads presented while busy show whether the window is restarted or the buffer is corrupted. Cycle-by-cycle sampling of busy and the fetched-data flag pins the four-clock window.

// File: rtl/msgx_pkg.sv
package msgx_pkg;
  localparam int REG_W    = 16;
  localparam int BUSY_BIT = 15;

  typedef enum logic {
    DIR_FETCH = 1'b0,
    DIR_STORE = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/msgx_remap.sv
module msgx_remap #(
  parameter int NUM_OBJ = 32,
  localparam int OBJ_W = $clog2(NUM_OBJ) + 1
) (
  input  logic [OBJ_W-1:0] num_in,
  output logic [OBJ_W-1:0] obj_out
);
  localparam logic [OBJ_W-1:0] TOP = OBJ_W'(NUM_OBJ);

  always_comb begin
    if (num_in == '0)
      obj_out = TOP;
    else if (num_in > TOP)
      obj_out = num_in - TOP;
    else
      obj_out = num_in;
  end
endmodule

// File: rtl/msgx_seq.sv
module msgx_seq #(
  parameter int LAT = 4,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic ram_go,
  output logic buf_take,
  output logic done
);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy     = busy_q;
  assign ram_go   = busy_q && (cnt_q == CW'(1));
  assign buf_take = busy_q && (cnt_q == CW'(2));
  assign done     = busy_q && (cnt_q == LAST);

  initial begin
    assert (LAT >= 3 && LAT <= 6) else $error("LAT out of window");
  end

  // R6: busy ends only after the full window has been counted
  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(cnt_q) == LAST);

  // R6: the count restarts at zero when busy rises
  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> cnt_q == '0);
endmodule

// File: rtl/msgx_ram.sv
module msgx_ram #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/msgx_top.sv
module msgx_top
  import msgx_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int DATA_W  = 64,
  parameter int LAT     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [REG_W-1:0]  cmd_wdata,
  input  logic              xfer_store,
  output logic [REG_W-1:0]  cmd_rdata,
  output logic              busy,
  input  logic              bin_valid,
  output logic              bin_ready,
  input  logic [DATA_W-1:0] bin_data,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_fetched
);
  localparam int AW    = $clog2(NUM_OBJ);
  localparam int OBJ_W = AW + 1;
  localparam int PAD_W = REG_W - 1 - OBJ_W;

  logic [OBJ_W-1:0]  obj_q, obj_next;
  xfer_dir_e         dir_q;
  logic [DATA_W-1:0] buf_q, ram_rdata;
  logic              fetched_q;
  logic              start, ram_go, buf_take, done;
  logic [AW-1:0]     ram_addr;
  logic              unused_hi;

  assign unused_hi = ^cmd_wdata[REG_W-1:OBJ_W];

  msgx_remap #(.NUM_OBJ(NUM_OBJ)) u_remap (
    .num_in (cmd_wdata[OBJ_W-1:0]),
    .obj_out(obj_next)
  );

  assign start = cmd_wr && !busy;

  msgx_seq #(.LAT(LAT)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .ram_go  (ram_go),
    .buf_take(buf_take),
    .done    (done)
  );

  // object n lives at entry n-1; the top object wraps to the last entry
  assign ram_addr = obj_q[AW-1:0] - 1'b1;

  msgx_ram #(.DEPTH(NUM_OBJ), .DATA_W(DATA_W)) u_ram (
    .clk  (clk),
    .en   (ram_go),
    .we   (dir_q == DIR_STORE),
    .addr (ram_addr),
    .wdata(buf_q),
    .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obj_q <= OBJ_W'(1);
      dir_q <= DIR_FETCH;
    end else if (start) begin
      obj_q <= obj_next;
      dir_q <= xfer_dir_e'(xfer_store);
    end
  end

  assign bin_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q     <= '0;
      fetched_q <= 1'b0;
    end else begin
      if (bin_valid && bin_ready) begin
        buf_q     <= bin_data;
        fetched_q <= 1'b0;
      end else if (start) begin
        fetched_q <= 1'b0;
      end
      if (buf_take && dir_q == DIR_FETCH) buf_q <= ram_rdata;
      if (done && dir_q == DIR_FETCH) fetched_q <= 1'b1;
    end
  end

  assign cmd_rdata   = {busy, {PAD_W{1'b0}}, obj_q};
  assign buf_data    = buf_q;
  assign buf_fetched = fetched_q;

  // R3 R4 R5: the selected object is always a valid one
  assert_obj_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    obj_q >= OBJ_W'(1) && obj_q <= OBJ_W'(NUM_OBJ));

  // R9: a command during busy leaves the object and direction alone
  assert_ignore_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr |=> $stable(obj_q) && $stable(dir_q));

  // R10: a load offered during a store window changes nothing in the buffer
  assert_hold_buf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bin_valid && dir_q == DIR_STORE |=> $stable(buf_q));

  // R8: completion of a fetch marks the buffer fresh
  assert_fetch_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && dir_q == DIR_FETCH |-> fetched_q);
endmodule

// File: tb/sim_msgx_top.sv
module sim_msgx_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_wdata = '0;
  logic        xfer_store = 1'b0;
  logic [15:0] cmd_rdata;
  logic        busy;
  logic        bin_valid = 1'b0;
  logic        bin_ready;
  logic [63:0] bin_data = '0;
  logic [63:0] buf_data;
  logic        buf_fetched;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msgx_top u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .xfer_store(xfer_store), .cmd_rdata(cmd_rdata), .busy(busy),
    .bin_valid(bin_valid), .bin_ready(bin_ready), .bin_data(bin_data),
    .buf_data(buf_data), .buf_fetched(buf_fetched)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a negedge
  task automatic issue(input logic [15:0] v, input bit store);
    cmd_wr = 1'b1; cmd_wdata = v; xfer_store = store;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_wdata = '0; xfer_store = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic load(input logic [63:0] d);
    bin_valid = 1'b1; bin_data = d;
    @(negedge clk);
    bin_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(cmd_rdata == 16'h0001, "R1 readback", cmd_rdata, 16'h0001);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(buf_fetched == 1'b0, "R1 fetched", buf_fetched, 0);
    check(bin_ready == 1'b1, "R1 ready", bin_ready, 1);
  endtask

  task automatic t_window();
    issue(16'h0005, 1'b0);
    check(cmd_rdata == 16'h8005, "R2 readback while busy", cmd_rdata, 16'h8005);
    for (int i = 0; i < 4; i++) begin
      check(busy == 1'b1, "R6 busy high in window", busy, 1);
      @(negedge clk);
    end
    check(busy == 1'b0, "R6 busy low after 4 clocks", busy, 0);
  endtask

  task automatic remap_one(input logic [15:0] v, input logic [15:0] exp, input string req);
    issue(v, 1'b0);
    wait_idle();
    check(cmd_rdata == exp, req, cmd_rdata, exp);
  endtask

  task automatic t_remap();
    remap_one(16'h0000, 16'h0020, "R4 zero maps to 0x20");
    remap_one(16'h0020, 16'h0020, "R3 upper bound 0x20");
    remap_one(16'h0001, 16'h0001, "R3 lower bound 0x01");
    remap_one(16'h0010, 16'h0010, "R3 mid value");
    remap_one(16'h0021, 16'h0001, "R5 0x21 to 0x01");
    remap_one(16'h003F, 16'h001F, "R5 0x3F to 0x1F");
    remap_one(16'hFFE5, 16'h0005, "R2 upper write bits ignored");
  endtask

  task automatic t_roundtrip();
    logic [63:0] pa = 64'hA5A5_0001_DEAD_BEEF;
    logic [63:0] pb = 64'h0123_4567_89AB_CDEF;
    load(pa); issue(16'h0003, 1'b1); wait_idle();
    load(pb); issue(16'h0000, 1'b1); wait_idle();
    load(64'h0); issue(16'h0001, 1'b1); wait_idle();
    issue(16'h0023, 1'b0);
    for (int i = 0; i < 4; i++) begin
      check(buf_fetched == 1'b0, "R8 flag low during fetch", buf_fetched, 0);
      @(negedge clk);
    end
    check(busy == 1'b0 && buf_fetched == 1'b1, "R8 flag rises as busy falls",
          {busy, buf_fetched}, 2'b01);
    check(buf_data == pa, "R7 R5 store then fetch via alias 0x23", buf_data, pa);
    issue(16'h0020, 1'b0); wait_idle();
    check(buf_data == pb, "R7 R4 object 0x20 via zero", buf_data, pb);
    issue(16'h0021, 1'b0); wait_idle();
    check(buf_data == 64'h0, "R7 object 1 entry", buf_data, 64'h0);
  endtask

  task automatic t_ignore_cmd();
    load(64'h7777_0000_0000_7777);
    issue(16'h0007, 1'b1);
    issue(16'h0009, 1'b0);
    check(cmd_rdata[5:0] == 6'h07, "R9 number kept", cmd_rdata[5:0], 6'h07);
    repeat (2) @(negedge clk);
    check(busy == 1'b1, "R9 window not ended early", busy, 1);
    @(negedge clk);
    check(busy == 1'b0, "R9 window not restarted", busy, 0);
    check(buf_fetched == 1'b0, "R9 direction kept (no fetch)", buf_fetched, 0);
    load(64'h0); issue(16'h0007, 1'b0); wait_idle();
    check(buf_data == 64'h7777_0000_0000_7777, "R9 store still happened",
          buf_data, 64'h7777_0000_0000_7777);
  endtask

  task automatic t_ignore_load();
    issue(16'h0007, 1'b0);
    check(bin_ready == 1'b0, "R10 ready low while busy", bin_ready, 0);
    bin_valid = 1'b1; bin_data = 64'hBAD0_BAD0_BAD0_BAD0;
    wait_idle();
    bin_valid = 1'b0;
    check(buf_data == 64'h7777_0000_0000_7777, "R10 held load ignored",
          buf_data, 64'h7777_0000_0000_7777);
    check(buf_fetched == 1'b1, "R8 flag after fetch", buf_fetched, 1);
    load(64'h55);
    check(buf_data == 64'h55 && buf_fetched == 1'b0, "R10 load replaces and clears flag",
          {buf_data[7:0], buf_fetched}, {8'h55, 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window();
    t_remap();
    t_roundtrip();
    t_ignore_cmd();
    t_ignore_load();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule